// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block holds the two architectural result registers of an integer core, HI and LO, and runs the multiply, divide and multiply-accumulate group against them. The issue stage presents an operation code and two operands with a one-cycle start strobe. The unit then raises `busy` until the work is finished and pulses `done` once. Multiplies finish after one cycle. Divides produce one quotient bit per cycle. Any result that spans 64 bits is split so that HI takes the upper half and LO the lower half.

The accumulate forms read HI and LO as a single 64-bit value, with HI as the upper word. They add the product to that value or subtract it, then write the sum back split across the two registers. A three-operand multiply returns only the low word of the signed product on its own output and leaves HI and LO untouched. Move-to operations write the first operand into HI or LO at once. Move-from reads are served by the `hiOut`/`loOut` ports, which carry a validity flag that is low while an operation is in flight.

Top module: `mduHiLoUnit`

## Requirements
- R1: Code 0 (signed) and code 1 (unsigned) multiply `opA` by `opB`, and write product bits 63:32 to HI and bits 31:0 to LO.
- R2: Code 2 (signed) and code 3 (unsigned) divide `opA` by `opB`, and write the quotient to LO and the remainder to HI. The signed quotient truncates toward zero and the signed remainder takes the sign of the dividend. The most negative dividend divided by -1 gives quotient 0x80000000 and remainder 0.
- R3: Codes 4 (signed) and 5 (unsigned) add the 64-bit product to {HI,LO}. Codes 6 (signed) and 7 (unsigned) subtract the product from {HI,LO}. The 64-bit result wraps and is written back as upper word to HI and lower word to LO.
- R4: Code 8 places the low 32 bits of the signed product on `mulLow` and leaves HI and LO unchanged.
- R5: Code 9 writes `opA` to HI and code 10 writes `opA` to LO, both at the accepting clock edge, with no busy period and no done pulse.
- R6: For codes 0, 1 and 4 to 8, `done` is high in the cycle after the first clock edge that follows acceptance. For codes 2 and 3, `done` is high DATA_W+1 cycles after acceptance (33 for 32-bit operands).
- R7: `done` lasts exactly one cycle, and `busy` is low whenever `done` is high.
- R8: A start strobe that arrives while `busy` is high is ignored, whatever its code.
- R9: While `busy` is high, `hiOut` and `loOut` keep their previous values and `outValid` is low. Otherwise `outValid` is high.
- R10: Codes 11 to 15 are ignored. They raise no busy, no done, and change neither HI nor LO.
- R11: A divide with `opB` equal to zero completes in the normal divide time and raises no error. The values it leaves in HI and LO are unspecified.
- R12: After reset, HI, LO and `mulLow` are zero, `busy` and `done` are low, and `outValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | One-cycle start strobe |
| opCode | input | 4 | Operation code (see R1 to R10) |
| opA | input | DATA_W | First operand (rs) |
| opB | input | DATA_W | Second operand (rt) |
| busy | output | 1 | An operation is in flight |
| done | output | 1 | One-cycle completion pulse |
| hiOut | output | DATA_W | Current HI value |
| loOut | output | DATA_W | Current LO value |
| outValid | output | 1 | HI/LO reads are valid (not busy) |
| mulLow | output | DATA_W | Low word of the last three-operand multiply |

## Verification
The properties assume three things about the inputs: `startValid` is a strobe whose code and operands matter only in the cycle it is high, every input is known from the end of reset onward, and a start given while busy is legal but carries no meaning. The bench drives each start on the falling edge and holds it for one cycle. It then waits for `done` before it issues the next operation, with one exception: a single deliberate overlapping start that exercises the ignore rule. Random codes span the whole 4-bit range, so invalid codes are mixed in with real operations. Divides by zero are directed, and afterwards the reference model copies HI and LO back from the ports.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [3:0] {
    OP_MULS = 4'd0,
    OP_MULU = 4'd1,
    OP_DIVS = 4'd2,
    OP_DIVU = 4'd3,
    OP_MACS = 4'd4,
    OP_MACU = 4'd5,
    OP_MSBS = 4'd6,
    OP_MSBU = 4'd7,
    OP_MUL3 = 4'd8,
    OP_WRHI = 4'd9,
    OP_WRLO = 4'd10
  } mduOp_e;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic loadOps;
    logic divStep;
    logic commitArith;
    logic commitDiv;
    logic writeHi;
    logic writeLo;
  } mduStrobe_t;

  function automatic logic isArithOp(logic [3:0] op);
    return (op <= 4'd1) || ((op >= 4'd4) && (op <= 4'd8));
  endfunction

  function automatic logic isDivOp(logic [3:0] op);
    return (op == 4'd2) || (op == 4'd3);
  endfunction

  function automatic logic isSignedOp(logic [3:0] op);
    return (op == 4'd8) || ((op < 4'd8) && !op[0]);
  endfunction

endpackage

// File: rtl/mduCtrl.sv
module mduCtrl
  import mdu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic [3:0] opCode,
  output mduStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DATA_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_MUL, S_DIV, S_FIN} state_e;

  state_e stateQ, stateD;
  logic [CNT_W-1:0] stepQ;
  logic accept;

  assign accept = startValid && (stateQ == S_IDLE);
  assign busy   = (stateQ != S_IDLE);

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    unique case (stateQ)
      S_IDLE: begin
        if (accept) begin
          if (isArithOp(opCode)) begin
            strobe.loadOps = 1'b1;
            stateD = S_MUL;
          end else if (isDivOp(opCode)) begin
            strobe.loadOps = 1'b1;
            stateD = S_DIV;
          end else if (opCode == OP_WRHI) begin
            strobe.writeHi = 1'b1;
          end else if (opCode == OP_WRLO) begin
            strobe.writeLo = 1'b1;
          end
        end
      end
      S_MUL: begin
        strobe.commitArith = 1'b1;
        stateD = S_IDLE;
      end
      S_DIV: begin
        strobe.divStep = 1'b1;
        if (stepQ == LAST_STEP) stateD = S_FIN;
      end
      S_FIN: begin
        strobe.commitDiv = 1'b1;
        stateD = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      stepQ  <= '0;
      done   <= 1'b0;
    end else begin
      stateQ <= stateD;
      done   <= (stateQ == S_MUL) || (stateQ == S_FIN);
      if (stateQ == S_DIV) stepQ <= stepQ + 1'b1;
      else                 stepQ <= '0;
    end
  end

endmodule

// File: rtl/mduData.sv
module mduData
  import mdu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  mduStrobe_t        strobe,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] hiOut,
  output logic [DATA_W-1:0] loOut,
  output logic [DATA_W-1:0] mulLow
);

  localparam int PROD_W = 2 * DATA_W;

  logic [3:0]        opReg;
  logic [DATA_W-1:0] aReg, bReg;
  logic [DATA_W-1:0] hiReg, loReg, lowReg;
  logic [DATA_W-1:0] quoReg, remReg, dvsReg;
  logic              negQ, negR;

  // Operand conditioning for the divider
  logic              sgnIn, aNeg, bNeg;
  logic [DATA_W-1:0] absA, absB;
  assign sgnIn = isSignedOp(opCode);
  assign aNeg  = sgnIn && opA[DATA_W-1];
  assign bNeg  = sgnIn && opB[DATA_W-1];
  assign absA  = aNeg ? (~opA + 1'b1) : opA;
  assign absB  = bNeg ? (~opB + 1'b1) : opB;

  // Full-width product from latched operands
  logic              sgnReg;
  logic [PROD_W-1:0] extA, extB, prod, acc;
  assign sgnReg = isSignedOp(opReg);
  assign extA   = {{DATA_W{sgnReg && aReg[DATA_W-1]}}, aReg};
  assign extB   = {{DATA_W{sgnReg && bReg[DATA_W-1]}}, bReg};
  assign prod   = extA * extB;
  assign acc    = {hiReg, loReg};

  // Restoring divide step
  logic [DATA_W:0] shifted, trial;
  assign shifted = {remReg, quoReg[DATA_W-1]};
  assign trial   = shifted - {1'b0, dvsReg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg  <= '0;
      aReg   <= '0;
      bReg   <= '0;
      hiReg  <= '0;
      loReg  <= '0;
      lowReg <= '0;
      quoReg <= '0;
      remReg <= '0;
      dvsReg <= '0;
      negQ   <= 1'b0;
      negR   <= 1'b0;
    end else begin
      if (strobe.loadOps) begin
        opReg  <= opCode;
        aReg   <= opA;
        bReg   <= opB;
        quoReg <= absA;
        remReg <= '0;
        dvsReg <= absB;
        negQ   <= aNeg ^ bNeg;
        negR   <= aNeg;
      end
      if (strobe.divStep) begin
        if (!trial[DATA_W]) begin
          remReg <= trial[DATA_W-1:0];
          quoReg <= {quoReg[DATA_W-2:0], 1'b1};
        end else begin
          remReg <= shifted[DATA_W-1:0];
          quoReg <= {quoReg[DATA_W-2:0], 1'b0};
        end
      end
      if (strobe.commitDiv) begin
        loReg <= negQ ? (~quoReg + 1'b1) : quoReg;
        hiReg <= negR ? (~remReg + 1'b1) : remReg;
      end
      if (strobe.commitArith) begin
        unique case (opReg)
          OP_MACS, OP_MACU: {hiReg, loReg} <= acc + prod;
          OP_MSBS, OP_MSBU: {hiReg, loReg} <= acc - prod;
          OP_MUL3:          lowReg <= prod[DATA_W-1:0];
          default:          {hiReg, loReg} <= prod;
        endcase
      end
      if (strobe.writeHi) hiReg <= opA;
      if (strobe.writeLo) loReg <= opA;
    end
  end

  assign hiOut  = hiReg;
  assign loOut  = loReg;
  assign mulLow = lowReg;

endmodule

// File: rtl/mduHiLoUnit.sv
module mduHiLoUnit
  import mdu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] hiOut,
  output logic [DATA_W-1:0] loOut,
  output logic              outValid,
  output logic [DATA_W-1:0] mulLow
);

  mduStrobe_t strobe;

  mduCtrl #(.DATA_W(DATA_W)) ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .opCode(opCode),
    .strobe(strobe), .busy(busy), .done(done)
  );

  mduData #(.DATA_W(DATA_W)) data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opCode(opCode),
    .opA(opA), .opB(opB), .hiOut(hiOut), .loOut(loOut), .mulLow(mulLow)
  );

  assign outValid = !busy;

endmodule

// File: rtl/mduHiLoUnit_chk.sv
module mduHiLoUnit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              startValid,
  input logic [3:0]        opCode,
  input logic [DATA_W-1:0] opA,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] hiOut,
  input logic [DATA_W-1:0] loOut
);

  localparam int CW = $clog2(DATA_W + 2) + 1;
  logic [CW-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else           busyCnt <= '0;
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_hold_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(hiOut) && $stable(loOut)));

  p_bad_code_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startValid && (opCode > 4'd10)) |=>
      (!busy && $stable(hiOut) && $stable(loOut)));

  p_move_hi_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startValid && (opCode == 4'd9)) |=>
      (!busy && (hiOut == $past(opA))));

  p_latency_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((busyCnt == CW'(1)) || (busyCnt == CW'(DATA_W + 1))));

endmodule

bind mduHiLoUnit mduHiLoUnit_chk #(.DATA_W(DATA_W)) chk (
  .clk(clk), .rstN(rstN), .startValid(startValid), .opCode(opCode),
  .opA(opA), .busy(busy), .done(done), .hiOut(hiOut), .loOut(loOut)
);

// File: tb/mduHiLoUnit_test.sv
module mduHiLoUnit_test;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startValid = 1'b0;
  logic [3:0]   opCode = '0;
  logic [W-1:0] opA = '0, opB = '0;
  logic         busy, done, outValid;
  logic [W-1:0] hiOut, loOut, mulLow;

  int nChecks = 0;
  int nFail = 0;
  logic [W-1:0] refHi = '0, refLo = '0, refLow = '0;

  always #5 clk = ~clk;

  mduHiLoUnit #(.DATA_W(W)) uut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .opCode(opCode),
    .opA(opA), .opB(opB), .busy(busy), .done(done), .hiOut(hiOut),
    .loOut(loOut), .outValid(outValid), .mulLow(mulLow)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit isLong(input logic [3:0] op);
    return (op <= 4'd8);
  endfunction

  // Updates the reference model; returns 0 when result is unspecified.
  function automatic bit model(input logic [3:0] op, input logic [W-1:0] a,
                               input logic [W-1:0] b);
    logic [63:0] sa, sb, ua, ub, ps, pu, acc;
    longint q, r;
    sa = {{32{a[31]}}, a}; sb = {{32{b[31]}}, b};
    ua = {32'b0, a};       ub = {32'b0, b};
    ps = sa * sb;          pu = ua * ub;
    acc = {refHi, refLo};
    case (op)
      4'd0: {refHi, refLo} = ps;
      4'd1: {refHi, refLo} = pu;
      4'd2: begin
        if (b == 0) return 1'b0;
        q = longint'($signed(a)) / longint'($signed(b));
        r = longint'($signed(a)) % longint'($signed(b));
        refLo = q[31:0]; refHi = r[31:0];
      end
      4'd3: begin
        if (b == 0) return 1'b0;
        refLo = a / b; refHi = a % b;
      end
      4'd4: {refHi, refLo} = acc + ps;
      4'd5: {refHi, refLo} = acc + pu;
      4'd6: {refHi, refLo} = acc - ps;
      4'd7: {refHi, refLo} = acc - pu;
      4'd8: refLow = ps[31:0];
      4'd9: refHi = a;
      4'd10: refLo = a;
      default: ;
    endcase
    return 1'b1;
  endfunction

  task automatic runOp(input logic [3:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input string req);
    int cyc;
    bit known;
    logic [W-1:0] oldHi, oldLo;
    oldHi = hiOut; oldLo = loOut;
    @(negedge clk);
    startValid = 1'b1; opCode = op; opA = a; opB = b;
    @(negedge clk);
    startValid = 1'b0;
    if (isLong(op)) begin
      check(busy && !outValid, "R9", "busy/outValid after start",
            {62'b0, busy, outValid}, 64'h2);
      check(hiOut == oldHi && loOut == oldLo, "R9", "held HI:LO while busy",
            {hiOut, loOut}, {oldHi, oldLo});
      cyc = 0;
      while (!done && cyc < 100) begin
        @(negedge clk);
        cyc++;
      end
      if (op == 4'd2 || op == 4'd3)
        check(cyc == W + 1, "R6", "divide latency", 64'(cyc), 64'(W + 1));
      else
        check(cyc == 1, "R6", "multiply latency", 64'(cyc), 64'd1);
      check(!busy && outValid, "R7", "idle at done",
            {62'b0, busy, outValid}, 64'h1);
      @(negedge clk);
      check(!done, "R7", "done single cycle", 64'(done), 64'd0);
    end else begin
      check(!busy && !done, (op > 4'd10) ? "R10" : "R5", "no busy/done",
            {62'b0, busy, done}, 64'h0);
    end
    known = model(op, a, b);
    if (known) begin
      check(hiOut == refHi && loOut == refLo, req, "HI:LO",
            {hiOut, loOut}, {refHi, refLo});
      check(mulLow == refLow, req, "mulLow", 64'(mulLow), 64'(refLow));
    end else begin
      refHi = hiOut; refLo = loOut;
    end
  endtask

  initial begin
    #(200000 * 10);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [W-1:0] ra, rb;
    logic [3:0] rop;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(hiOut == 0 && loOut == 0 && mulLow == 0, "R12", "reset values",
          {hiOut, loOut}, 64'd0);
    check(!busy && !done && outValid, "R12", "reset flags",
          {61'b0, busy, done, outValid}, 64'h1);

    runOp(4'd9, 32'h1234_5678, 32'h0, "R5");
    runOp(4'd10, 32'h9ABC_DEF0, 32'h0, "R5");
    runOp(4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1");
    runOp(4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1");
    runOp(4'd0, 32'h8000_0000, 32'h0000_0003, "R1");
    runOp(4'd2, 32'hFFFF_FFF9, 32'h0000_0002, "R2");
    runOp(4'd2, 32'h0000_0007, 32'hFFFF_FFFE, "R2");
    runOp(4'd2, 32'h8000_0000, 32'hFFFF_FFFF, "R2");
    runOp(4'd3, 32'hFFFF_FFFF, 32'h0000_0010, "R2");
    runOp(4'd4, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R3");
    runOp(4'd5, 32'hFFFF_FFFF, 32'h0000_0002, "R3");
    runOp(4'd6, 32'hFFFF_FFFF, 32'h0000_0005, "R3");
    runOp(4'd7, 32'h0001_0000, 32'h0001_0000, "R3");
    runOp(4'd8, 32'hFFFF_FFFD, 32'h0000_0007, "R4");
    runOp(4'd12, 32'h1111_1111, 32'h2222_2222, "R10");
    runOp(4'd15, 32'h3333_3333, 32'h4444_4444, "R10");
    runOp(4'd3, 32'h0000_0005, 32'h0000_0000, "R11");
    runOp(4'd2, 32'h8000_0000, 32'h0000_0000, "R11");

    // R8: overlapping start during a divide is ignored
    @(negedge clk);
    startValid = 1'b1; opCode = 4'd3; opA = 32'd100; opB = 32'd7;
    @(negedge clk);
    opCode = 4'd9; opA = 32'hDEAD_BEEF;
    @(negedge clk);
    startValid = 1'b0;
    begin
      int cyc = 0;
      while (!done && cyc < 100) begin
        @(negedge clk);
        cyc++;
      end
    end
    refHi = 32'd2; refLo = 32'd14;
    check(hiOut == refHi && loOut == refLo, "R8", "start while busy ignored",
          {hiOut, loOut}, {refHi, refLo});
    @(negedge clk);
    check(!busy, "R8", "no extra busy", 64'(busy), 64'd0);

    for (int i = 0; i < 200; i++) begin
      rop = 4'($urandom_range(0, 15));
      ra = $urandom();
      rb = $urandom();
      if (rop == 4'd2 || rop == 4'd3) rb = rb >> $urandom_range(0, 28);
      runOp(rop, ra, rb, "R1 R2 R3 R4 R5 R10 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule